// File: doc/BRIEF.md
# Fuse Program Request Lock Checker

This block stands between a software-facing program request and a one-time-programmable fuse array. Each request names a single fuse bit through a packed page/row/column address. The block decides whether that bit may be burnt. If it may, the block raises a one-cycle set strobe with the address. Every request ends with a one-cycle done pulse. A denied request also raises an error pulse in that same cycle.

The decision combines several inputs. The first is a global program-enable level. The second is a sticky software lock, which protects a band of page-0 rows. The third is a fixed table that ties protected page-0 rows to a lock fuse. The last is a narrow programmable window on page 2, guarded by its own lock fuse. The block reads lock fuses through a combinational lookup port: it drives a packed fuse address and reads back that fuse's bit in the same cycle.

Requests arrive on a valid/ready channel. `req_ready` is high only when no request is in flight. A request is taken at a rising edge where both `req_valid` and `req_ready` are high. The source must hold `req_valid` and `req_addr` until that edge. While a request is in flight, `req_ready` stays low, so the source is held off.

Top module: `fuse_pgm_guard`

## Requirements
- R1: Addresses pack the page in bits 16:13, the row in bits 12:5 and the column in bits 4:0. An allowed request presents the unchanged request address on `set_addr` while `set_valid` is high.
- R2: While `cfg_pgm_en` is 0 at the decision edge, every request is denied.
- R3: `swlock_set` sets a sticky lock that only reset clears. While the lock is set, page-0 rows 44 to 51 are denied. Before it is set, those rows are allowed.
- R4: Each of these page-0 row bands is denied when its lock fuse reads 1, and allowed when it reads 0. Every one of these lock fuses is on page 0, row 43, at the column given after the band:
  - rows 8–11: column 27
  - rows 12–19: column 11
  - rows 20–27: column 13
  - rows 28–35: column 15
  - rows 64–71: column 6
  - rows 72–79: column 7
  - rows 80–87: column 8
- R5: Page-0 row 4 is guarded by the fuse at page 0, row 4, column 31. Page-0 row 37 is guarded by the fuse at page 0, row 43, column 28.
- R6: On page 2, a bit is eligible only if its (row, column) position lies between (129, 0) and (255, 27) inclusive. An eligible bit is denied when the fuse at page 0, row 43, column 16 reads 1. Positions outside the window are denied.
- R7: Requests to any page other than 0 or 2 are denied.
- R8: Page-0 rows that have no lock entry are allowed whenever programming is enabled and the software lock does not cover them.
- R9: Every accepted request produces exactly one done pulse, in the cycle after the second rising edge that follows acceptance. An error pulse in the same cycle means the request was denied; a set strobe in the same cycle means it was allowed. The two never occur together.
- R10: `req_ready` is low from acceptance until the report cycle ends. A valid presented in that time is not taken and produces no report.
- R11: After reset, `req_ready` is high and `done_pulse`, `err_pulse` and `set_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_pgm_en | input | 1 | Global program enable |
| swlock_set | input | 1 | Pulse that sets the sticky software lock |
| req_valid | input | 1 | Program request valid |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | 17 | Packed page/row/column of the bit to program |
| lk_addr | output | 17 | Packed address of the lock fuse being consulted |
| lk_bit | input | 1 | Value of the fuse at `lk_addr`, same cycle |
| set_valid | output | 1 | One-cycle strobe: program this bit |
| set_addr | output | 17 | Address to program, valid with `set_valid` |
| done_pulse | output | 1 | One-cycle completion pulse |
| err_pulse | output | 1 | One-cycle denial pulse, with `done_pulse` |

## Verification
The assertions make three assumptions about the inputs.
- `cfg_pgm_en` is a level that the environment drives cleanly at every clock edge.
- `lk_bit` answers `lk_addr` combinationally, with no added delay.
- The source obeys the valid/ready rule, holding its address until acceptance.

The bench meets these assumptions as follows. It changes `cfg_pgm_en` and `swlock_set` only between requests. Its lock-fuse model is a purely combinational function of `lk_addr`. It drives every request at the falling edge and releases it right after the accepting edge. Its one deliberate violation is raising `req_valid` while the block is busy; the bench drops it again before `req_ready` can return.

// File: rtl/fpg_pkg.sv
package fpg_pkg;
  localparam int PAGE_W = 4;
  localparam int ROW_W  = 8;
  localparam int COL_W  = 5;
  localparam int POS_W  = ROW_W + COL_W;
  localparam int ADDR_W = PAGE_W + POS_W;

  localparam logic [PAGE_W-1:0] PAGE_MAIN   = 4'd0;
  localparam logic [PAGE_W-1:0] PAGE_WINDOW = 4'd2;

  // Rows guarded by the sticky software lock on the main page
  localparam logic [ROW_W-1:0] SWZ_LO = 8'd44;
  localparam logic [ROW_W-1:0] SWZ_HI = 8'd51;

  // Programmable window on the window page, as {row, col} positions
  localparam logic [POS_W-1:0] WIN_LO = {8'd129, 5'd0};
  localparam logic [POS_W-1:0] WIN_HI = {8'd255, 5'd27};
  localparam logic [ROW_W-1:0] WIN_LK_ROW = 8'd43;
  localparam logic [COL_W-1:0] WIN_LK_COL = 5'd16;

  typedef struct packed {
    logic [ROW_W-1:0] first;
    logic [ROW_W-1:0] last;
    logic [ROW_W-1:0] lk_row;
    logic [COL_W-1:0] lk_col;
  } guard_span_t;

  localparam int NUM_SPANS = 9;

  localparam guard_span_t GUARD_SPANS [NUM_SPANS] = '{
    '{first: 8'd4,  last: 8'd4,  lk_row: 8'd4,  lk_col: 5'd31},
    '{first: 8'd37, last: 8'd37, lk_row: 8'd43, lk_col: 5'd28},
    '{first: 8'd64, last: 8'd71, lk_row: 8'd43, lk_col: 5'd6},
    '{first: 8'd72, last: 8'd79, lk_row: 8'd43, lk_col: 5'd7},
    '{first: 8'd80, last: 8'd87, lk_row: 8'd43, lk_col: 5'd8},
    '{first: 8'd12, last: 8'd19, lk_row: 8'd43, lk_col: 5'd11},
    '{first: 8'd20, last: 8'd27, lk_row: 8'd43, lk_col: 5'd13},
    '{first: 8'd28, last: 8'd35, lk_row: 8'd43, lk_col: 5'd15},
    '{first: 8'd8,  last: 8'd11, lk_row: 8'd43, lk_col: 5'd27}
  };

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOOK   = 2'd1,
    ST_REPORT = 2'd2
  } seq_state_t;
endpackage

// File: rtl/fpg_addr_decode.sv
module fpg_addr_decode
  import fpg_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output logic              page_ok,
  output logic              in_swzone,
  output logic              lk_need,
  output logic [ROW_W-1:0]  lk_row,
  output logic [COL_W-1:0]  lk_col
);
  logic [PAGE_W-1:0] page;
  logic [ROW_W-1:0]  row;
  logic [POS_W-1:0]  pos;

  assign page = addr[ADDR_W-1 -: PAGE_W];
  assign row  = addr[POS_W-1 -: ROW_W];
  assign pos  = addr[POS_W-1:0];

  always_comb begin
    page_ok   = 1'b0;
    in_swzone = 1'b0;
    lk_need   = 1'b0;
    lk_row    = '0;
    lk_col    = '0;
    if (page == PAGE_MAIN) begin
      page_ok   = 1'b1;
      in_swzone = (row >= SWZ_LO) && (row <= SWZ_HI);
      for (int i = 0; i < NUM_SPANS; i++) begin
        if ((row >= GUARD_SPANS[i].first) && (row <= GUARD_SPANS[i].last)) begin
          lk_need = 1'b1;
          lk_row  = GUARD_SPANS[i].lk_row;
          lk_col  = GUARD_SPANS[i].lk_col;
        end
      end
    end else if (page == PAGE_WINDOW) begin
      if ((pos >= WIN_LO) && (pos <= WIN_HI)) begin
        page_ok = 1'b1;
        lk_need = 1'b1;
        lk_row  = WIN_LK_ROW;
        lk_col  = WIN_LK_COL;
      end
    end
  end
endmodule

// File: rtl/fpg_verdict.sv
module fpg_verdict (
  input  logic pgm_en,
  input  logic swlock,
  input  logic page_ok,
  input  logic in_swzone,
  input  logic lk_need,
  input  logic lk_bit,
  output logic deny
);
  logic gate_off;
  logic sw_block;
  logic fuse_block;

  assign gate_off   = !pgm_en || !page_ok;
  assign sw_block   = swlock && in_swzone;
  assign fuse_block = lk_need && lk_bit;
  assign deny       = gate_off || sw_block || fuse_block;
endmodule

// File: rtl/fpg_seq.sv
module fpg_seq
  import fpg_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [AW-1:0] in_addr,
  input  logic          deny,
  output logic [AW-1:0] addr_q,
  output logic          set_valid,
  output logic          done_pulse,
  output logic          err_pulse
);
  seq_state_t state;

  assign in_ready = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      addr_q     <= '0;
      set_valid  <= 1'b0;
      done_pulse <= 1'b0;
      err_pulse  <= 1'b0;
    end else begin
      set_valid  <= 1'b0;
      done_pulse <= 1'b0;
      err_pulse  <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (in_valid) begin
            addr_q <= in_addr;
            state  <= ST_LOOK;
          end
        end
        ST_LOOK: begin
          done_pulse <= 1'b1;
          err_pulse  <= deny;
          set_valid  <= !deny;
          state      <= ST_REPORT;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_ONE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> !done_pulse); // R9
  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> ##1 done_pulse); // R9
  AST_ERR_XOR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> (err_pulse != set_valid)); // R9
  AST_OUT_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (err_pulse || set_valid) |-> done_pulse); // R9
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready); // R10
  AST_REPORT_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> !in_ready); // R10
endmodule

// File: rtl/fuse_pgm_guard.sv
module fuse_pgm_guard
  import fpg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_pgm_en,
  input  logic              swlock_set,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic [ADDR_W-1:0] lk_addr,
  input  logic              lk_bit,
  output logic              set_valid,
  output logic [ADDR_W-1:0] set_addr,
  output logic              done_pulse,
  output logic              err_pulse
);
  logic [ADDR_W-1:0] addr_q;
  logic              swlock_q;
  logic              page_ok;
  logic              in_swzone;
  logic              lk_need;
  logic [ROW_W-1:0]  lk_row;
  logic [COL_W-1:0]  lk_col;
  logic              deny;

  always_ff @(posedge clk) begin
    if (!rst_n) swlock_q <= 1'b0;
    else        swlock_q <= swlock_q || swlock_set;
  end

  fpg_addr_decode u_decode (
    .addr      (addr_q),
    .page_ok   (page_ok),
    .in_swzone (in_swzone),
    .lk_need   (lk_need),
    .lk_row    (lk_row),
    .lk_col    (lk_col)
  );

  assign lk_addr = {PAGE_MAIN, lk_row, lk_col};

  fpg_verdict u_verdict (
    .pgm_en    (cfg_pgm_en),
    .swlock    (swlock_q),
    .page_ok   (page_ok),
    .in_swzone (in_swzone),
    .lk_need   (lk_need),
    .lk_bit    (lk_bit),
    .deny      (deny)
  );

  fpg_seq #(.AW(ADDR_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (req_valid),
    .in_ready   (req_ready),
    .in_addr    (req_addr),
    .deny       (deny),
    .addr_q     (addr_q),
    .set_valid  (set_valid),
    .done_pulse (done_pulse),
    .err_pulse  (err_pulse)
  );

  assign set_addr = addr_q;

  AST_SET_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    set_valid |-> $past(cfg_pgm_en)); // R2
  AST_SET_PAGE_OK: assert property (@(posedge clk) disable iff (!rst_n)
    set_valid |-> (set_addr[ADDR_W-1 -: PAGE_W] == PAGE_MAIN ||
                   set_addr[ADDR_W-1 -: PAGE_W] == PAGE_WINDOW)); // R7
  AST_SWLOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (set_valid && swlock_q && set_addr[ADDR_W-1 -: PAGE_W] == PAGE_MAIN)
      |-> !(set_addr[POS_W-1 -: ROW_W] >= SWZ_LO &&
            set_addr[POS_W-1 -: ROW_W] <= SWZ_HI)); // R3
endmodule

// File: tb/fuse_pgm_guard_tb_top.sv
module fuse_pgm_guard_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_pgm_en = 1'b0;
  logic        swlock_set = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [16:0] req_addr = '0;
  logic [16:0] lk_addr;
  logic        lk_bit;
  logic        set_valid;
  logic [16:0] set_addr;
  logic        done_pulse;
  logic        err_pulse;

  int errors = 0;
  int checks = 0;
  logic [31:0] fz_r43 = '0;
  logic        fz_r4c31 = 1'b0;
  logic        tb_swl = 1'b0;

  always #5 clk = ~clk;

  // combinational lock-fuse model, page 0 only
  always_comb begin
    lk_bit = 1'b0;
    if (lk_addr[16:13] == 4'd0) begin
      if (lk_addr[12:5] == 8'd43) lk_bit = fz_r43[lk_addr[4:0]];
      else if (lk_addr[12:5] == 8'd4 && lk_addr[4:0] == 5'd31) lk_bit = fz_r4c31;
    end
  end

  fuse_pgm_guard dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_pgm_en(cfg_pgm_en), .swlock_set(swlock_set),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .lk_addr(lk_addr), .lk_bit(lk_bit), .set_valid(set_valid),
    .set_addr(set_addr), .done_pulse(done_pulse), .err_pulse(err_pulse)
  );

  function automatic logic [16:0] mk(input int pg, input int row, input int col);
    return {pg[3:0], row[7:0], col[4:0]};
  endfunction

  function automatic logic exp_deny(input logic [16:0] a);
    int pg  = int'(a[16:13]);
    int row = int'(a[12:5]);
    int pos = int'(a[12:0]);
    if (!cfg_pgm_en) return 1'b1;
    if (pg == 0) begin
      if (tb_swl && row >= 44 && row <= 51) return 1'b1;
      if (row == 4) return fz_r4c31;
      if (row == 37) return fz_r43[28];
      if (row >= 8 && row <= 11) return fz_r43[27];
      if (row >= 12 && row <= 19) return fz_r43[11];
      if (row >= 20 && row <= 27) return fz_r43[13];
      if (row >= 28 && row <= 35) return fz_r43[15];
      if (row >= 64 && row <= 71) return fz_r43[6];
      if (row >= 72 && row <= 79) return fz_r43[7];
      if (row >= 80 && row <= 87) return fz_r43[8];
      return 1'b0;
    end
    if (pg == 2) begin
      if (pos < (129 * 32) || pos > (255 * 32 + 27)) return 1'b1;
      return fz_r43[16];
    end
    return 1'b1;
  endfunction

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one request; busy=1 also pokes req_valid while in flight
  task automatic do_req(input logic [16:0] a, input string req, input bit busy);
    logic e;
    e = exp_deny(a);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk(done_pulse == 1'b0, "R9", "no early done", 32'(done_pulse), 0);
    if (busy) begin
      chk(req_ready == 1'b0, "R10", "ready low in flight", 32'(req_ready), 0);
      req_valid = 1'b1;
      req_addr  = mk(0, 100, 1);
    end
    @(negedge clk);
    req_valid = 1'b0;
    chk(done_pulse == 1'b1, "R9", "done after two edges", 32'(done_pulse), 1);
    chk(err_pulse == e, req, "err", 32'(err_pulse), 32'(e));
    chk(set_valid == !e, req, "set", 32'(set_valid), 32'(!e));
    if (!e) chk(set_addr == a, "R1", "set_addr", 32'(set_addr), 32'(a));
    @(negedge clk);
    chk(done_pulse == 1'b0, "R9", "single done", 32'(done_pulse), 0);
    if (busy) begin
      repeat (3) begin
        @(negedge clk);
        chk(done_pulse == 1'b0, "R10", "busy valid ignored", 32'(done_pulse), 0);
      end
    end
  endtask

  task automatic t_reset();
    chk(req_ready == 1'b1, "R11", "ready", 32'(req_ready), 1);
    chk(!done_pulse && !err_pulse && !set_valid, "R11", "outputs idle",
        {29'd0, done_pulse, err_pulse, set_valid}, 0);
  endtask

  task automatic t_disabled();
    cfg_pgm_en = 1'b0;
    do_req(mk(0, 100, 3), "R2", 0);
    do_req(mk(2, 200, 0), "R2", 0);
    cfg_pgm_en = 1'b1;
  endtask

  task automatic t_unlisted();
    do_req(mk(0, 100, 3), "R8", 0);
    do_req(mk(0, 0, 0), "R8", 0);
    do_req(mk(0, 43, 16), "R8", 0);
  endtask

  task automatic t_table();
    do_req(mk(0, 12, 0), "R4", 0);
    fz_r43[11] = 1'b1;
    do_req(mk(0, 19, 31), "R4", 0);
    do_req(mk(0, 20, 5), "R4", 0);
    fz_r43[13] = 1'b1; do_req(mk(0, 27, 5), "R4", 0);
    fz_r43[15] = 1'b1; do_req(mk(0, 30, 2), "R4", 0);
    fz_r43[6]  = 1'b1; do_req(mk(0, 64, 0), "R4", 0);
    do_req(mk(0, 72, 0), "R4", 0);
    fz_r43[7]  = 1'b1; do_req(mk(0, 79, 9), "R4", 0);
    fz_r43[8]  = 1'b1; do_req(mk(0, 87, 9), "R4", 0);
    do_req(mk(0, 88, 9), "R8", 0);
    fz_r43[27] = 1'b1; do_req(mk(0, 8, 1), "R4", 0);
  endtask

  task automatic t_special();
    do_req(mk(0, 4, 0), "R5", 0);
    fz_r4c31 = 1'b1; do_req(mk(0, 4, 7), "R5", 0);
    do_req(mk(0, 37, 1), "R5", 0);
    fz_r43[28] = 1'b1; do_req(mk(0, 37, 1), "R5", 0);
  endtask

  task automatic t_page2();
    do_req(mk(2, 128, 31), "R6", 0);
    do_req(mk(2, 129, 0), "R6", 0);
    do_req(mk(2, 255, 27), "R6", 0);
    do_req(mk(2, 255, 28), "R6", 0);
    fz_r43[16] = 1'b1; do_req(mk(2, 200, 4), "R6", 0);
  endtask

  task automatic t_badpage();
    do_req(mk(1, 100, 0), "R7", 0);
    do_req(mk(3, 10, 0), "R7", 0);
    do_req(mk(15, 200, 0), "R7", 0);
  endtask

  task automatic t_swlock();
    do_req(mk(0, 44, 0), "R3", 0);
    @(negedge clk); swlock_set = 1'b1;
    @(negedge clk); swlock_set = 1'b0; tb_swl = 1'b1;
    do_req(mk(0, 44, 0), "R3", 0);
    do_req(mk(0, 51, 31), "R3", 0);
    do_req(mk(0, 52, 0), "R3", 0);
    do_req(mk(0, 48, 3), "R3", 0);
  endtask

  task automatic t_busy();
    do_req(mk(0, 90, 2), "R10", 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_unlisted();
    t_busy();
    t_table();
    t_special();
    t_page2();
    t_badpage();
    t_swlock();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule